// File: doc/BRIEF.md
# Dual-Chain Detection Result Framer

Two detection chains each deliver 32-bit result words one at a time while a processing interval runs. When a chain has finished, it raises a level done flag. The framer stores each word in a memory region that belongs only to that chain. On the rising edge of the done flag it completes the frame around those words. It writes an identifier, the number of data words, the number of detected targets and a checksum. It then pulses an interrupt line that serves only that chain. A host reads the finished frame through a synchronous read port.

The identifier layout depends on the chain. Chain 0 carries the pulse counter and the interval counter. Chain 1 carries the interval counter and a waveform code. The target count travels in its own word because the number of detections changes between intervals. A host that reads a shorter frame after a longer one can then tell where the valid data ends. One shared sequencer completes the frames. If both chains finish in the same cycle, chain 0 is served first and then chain 1, and each chain still gets its own interrupt pulse.

Top module: `rf_top`

## Requirements
- R1: A chain's region holds, at offsets 0, 1 and 2, the identifier, the data word count L and the target count zero-extended to 32 bits. The data words follow at offsets 3 to 3+L-1 in arrival order, and the checksum is at offset 3+L.
- R2: For chain 0 the identifier is pulse counter in bits 31:16 and interval counter in bits 15:0. For chain 1 it is interval counter in bits 31:16, zero in bits 15:7 and waveform code in bits 6:0. Both are sampled on the edge that first sees the done flag high.
- R3: The checksum is the sum, modulo 2^32, of the identifier, L, the target count word and all L data words.
- R4: A chain's interrupt goes high on the 5th clock edge after the edge that first samples its done flag high, provided no other frame is in progress. It stays high for exactly IRQ_CYCLES cycles. A done flag that stays high does not raise another interrupt.
- R5: When both done flags rise in the same cycle, chain 0 is framed first and chain 1's interrupt rises 5 edges after chain 0's. Each chain drives only its own interrupt line.
- R6: A chain's busy output is high from the edge after its done rising edge until the edge on which its checksum is written. While busy is high, that chain's incoming words and done edges are ignored and do not appear in the next frame.
- R7: Words beyond MAX_WORDS in one frame are dropped, and L saturates at MAX_WORDS.
- R8: Read address bit AW selects the chain region and the lower AW bits select the offset. Read data appears one cycle after the address. Framing one chain never alters the other chain's region.
- R9: After reset, both interrupts and both busy outputs are low and both word counts are zero. A done edge with no words therefore yields a frame with L = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_i | input | 2 | Per-chain completion level flag |
| wvld_i | input | 2 | Per-chain result word valid |
| wdata_i | input | 64 | Result words, chain c in bits 32c+31:32c |
| tcount_i | input | 2*CNT_W | Target counts, chain c in bits CNT_W*c+CNT_W-1:CNT_W*c |
| pri_cnt_i | input | 16 | Pulse counter for identifiers |
| cpi_cnt_i | input | 16 | Interval counter for identifiers |
| wave_i | input | 7 | Waveform code for chain 1 identifiers |
| busy_o | output | 2 | Per-chain frame in progress |
| irq_o | output | 2 | Per-chain interrupt pulse |
| rd_addr_i | input | AW+1 | Host read address {chain, offset} |
| rd_data_o | output | 32 | Host read data, one cycle latency |

## Verification
Every result has a fixed delay from the edge that first samples a rising done flag. Busy is due after 1 edge. The interrupt is due after 5 edges, or after 10 edges for chain 1 when both chains finish together. Read data is due 1 cycle after the address. A behavioural model in the bench advances on each rising edge with the same sampled inputs. The interrupt and busy outputs are compared against it on every falling edge. Frame contents are read back while the block is idle and compared offset by offset with frames the model built from its own word queues.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int NCH = 2;

  typedef enum logic [1:0] {ST_ID, ST_LEN, ST_CNT, ST_SUM} step_e;

  function automatic logic [31:0] make_id(input logic chain, input logic [15:0] pri,
                                          input logic [15:0] cpi, input logic [6:0] wave);
    return chain ? {cpi, 9'd0, wave} : {pri, cpi};
  endfunction
endpackage

// File: rtl/rf_collect.sv
module rf_collect #(
  parameter int MAX_WORDS = 12,
  parameter int AW = 4,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wvld,
  input  logic [31:0]   wdata,
  input  logic          block,
  input  logic          clr,
  input  logic          seq_we,
  input  logic [AW-1:0] seq_addr,
  input  logic [31:0]   seq_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_q,
  output logic [LW-1:0] wcnt_o,
  output logic [31:0]   sum_o
);
  localparam int DEPTH = 1 << AW;

  logic [31:0]   mem [DEPTH];
  logic          take, we;
  logic [AW-1:0] addr;
  logic [31:0]   din;

  assign take = wvld && !block && (wcnt_o < LW'(MAX_WORDS));
  assign we   = take || seq_we;
  assign addr = seq_we ? seq_addr : (AW'(wcnt_o) + AW'(3));
  assign din  = seq_we ? seq_data : wdata;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= din;
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wcnt_o <= '0;
      sum_o  <= '0;
    end else if (take) begin
      wcnt_o <= wcnt_o + LW'(1);
      sum_o  <= sum_o + wdata;
    end
  end

  AST_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(take && seq_we)); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst) (block && !clr) |=> $stable(wcnt_o)); // R6
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (rst) wcnt_o <= LW'(MAX_WORDS)); // R7
endmodule

// File: rtl/rf_irq.sv
module rf_irq #(
  parameter int IRQ_CYCLES = 4,
  parameter int CW = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic done,
  input  logic fire,
  output logic rise,
  output logic irq
);
  logic          done_q;
  logic [CW-1:0] cnt;

  assign rise = done && !done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      irq    <= 1'b0;
      cnt    <= '0;
    end else begin
      done_q <= done;
      if (fire) begin
        irq <= 1'b1;
        cnt <= CW'(IRQ_CYCLES - 1);
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
      end else begin
        irq <= 1'b0;
      end
    end
  end

  AST_IRQ_ON_FIRE: assert property (@(posedge clk) disable iff (rst) fire |=> irq); // R4
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(irq) |-> $past(fire)); // R4
endmodule

// File: rtl/rf_seq.sv
module rf_seq
  import rf_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int AW = 4,
  parameter int LW = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NCH-1:0]     rise,
  input  logic [15:0]        pri,
  input  logic [15:0]        cpi,
  input  logic [6:0]         wave,
  input  logic [NCH*CNT_W-1:0] tcount,
  input  logic [NCH*LW-1:0]  wcnt,
  input  logic [NCH*32-1:0]  sum,
  output logic [NCH-1:0]     pend,
  output logic [NCH-1:0]     we,
  output logic [AW-1:0]      waddr,
  output logic [31:0]        wdata,
  output logic [NCH-1:0]     fin
);
  logic             act, sel;
  step_e            step;
  logic [31:0]      id_s  [NCH];
  logic [CNT_W-1:0] cnt_s [NCH];
  logic [LW-1:0]    len_sel;
  logic [31:0]      sum_sel, len_w, cnt_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      act  <= 1'b0;
      sel  <= 1'b0;
      step <= ST_ID;
    end else begin
      for (int c = 0; c < NCH; c++)
        if (rise[c] && !pend[c]) pend[c] <= 1'b1;
      if (!act) begin
        if (|pend) begin
          act  <= 1'b1;
          sel  <= !pend[0];
          step <= ST_ID;
        end
      end else if (step == ST_SUM) begin
        act       <= 1'b0;
        pend[sel] <= 1'b0;
      end else begin
        step <= step_e'(step + 2'd1);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++)
      if (rise[c] && !pend[c]) begin
        id_s[c]  <= make_id(c[0], pri, cpi, wave);
        cnt_s[c] <= tcount[c*CNT_W +: CNT_W];
      end
  end

  assign len_sel = sel ? wcnt[LW +: LW] : wcnt[0 +: LW];
  assign sum_sel = sel ? sum[32 +: 32] : sum[0 +: 32];
  assign len_w   = 32'(len_sel);
  assign cnt_w   = 32'(cnt_s[sel]);

  always_comb begin
    we  = '0;
    fin = '0;
    we[sel]  = act;
    fin[sel] = act && (step == ST_SUM);
    case (step)
      ST_ID:   begin waddr = AW'(0); wdata = id_s[sel]; end
      ST_LEN:  begin waddr = AW'(1); wdata = len_w; end
      ST_CNT:  begin waddr = AW'(2); wdata = cnt_w; end
      default: begin waddr = AW'(len_sel) + AW'(3); wdata = id_s[sel] + len_w + cnt_w + sum_sel; end
    endcase
  end

  AST_SERVE_PENDING: assert property (@(posedge clk) disable iff (rst) act |-> pend[sel]); // R6
  AST_ONE_FINISH: assert property (@(posedge clk) disable iff (rst) $onehot0(fin)); // R5
  AST_PRIORITY: assert property (@(posedge clk) disable iff (rst) (!act && pend[0]) |=> !sel); // R5
endmodule

// File: rtl/rf_top.sv
module rf_top
  import rf_pkg::*;
#(
  parameter int MAX_WORDS  = 12,
  parameter int IRQ_CYCLES = 4,
  parameter int CNT_W      = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [1:0]                        done_i,
  input  logic [1:0]                        wvld_i,
  input  logic [63:0]                       wdata_i,
  input  logic [2*CNT_W-1:0]                tcount_i,
  input  logic [15:0]                       pri_cnt_i,
  input  logic [15:0]                       cpi_cnt_i,
  input  logic [6:0]                        wave_i,
  output logic [1:0]                        busy_o,
  output logic [1:0]                        irq_o,
  input  logic [$clog2(MAX_WORDS+4):0]      rd_addr_i,
  output logic [31:0]                       rd_data_o
);
  localparam int AW = $clog2(MAX_WORDS + 4);
  localparam int LW = $clog2(MAX_WORDS + 1);
  localparam int CW = $clog2(IRQ_CYCLES + 1);

  logic [NCH-1:0]    rise, pend, we, fin;
  logic [AW-1:0]     waddr;
  logic [31:0]       wdata;
  logic [NCH*LW-1:0] wcnt;
  logic [NCH*32-1:0] sum;
  logic [31:0]       bank_q [NCH];
  logic              rd_sel_q;

  rf_seq #(.CNT_W(CNT_W), .AW(AW), .LW(LW)) u_seq (
    .clk(clk), .rst(rst), .rise(rise), .pri(pri_cnt_i), .cpi(cpi_cnt_i), .wave(wave_i),
    .tcount(tcount_i), .wcnt(wcnt), .sum(sum), .pend(pend), .we(we), .waddr(waddr),
    .wdata(wdata), .fin(fin)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chain
    rf_collect #(.MAX_WORDS(MAX_WORDS), .AW(AW), .LW(LW)) u_col (
      .clk(clk), .rst(rst), .wvld(wvld_i[c]), .wdata(wdata_i[c*32 +: 32]),
      .block(pend[c]), .clr(fin[c]), .seq_we(we[c]), .seq_addr(waddr), .seq_data(wdata),
      .rd_addr(rd_addr_i[AW-1:0]), .rd_q(bank_q[c]), .wcnt_o(wcnt[c*LW +: LW]),
      .sum_o(sum[c*32 +: 32])
    );

    rf_irq #(.IRQ_CYCLES(IRQ_CYCLES), .CW(CW)) u_irq (
      .clk(clk), .rst(rst), .done(done_i[c]), .fire(fin[c]), .rise(rise[c]), .irq(irq_o[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_sel_q <= 1'b0;
    else     rd_sel_q <= rd_addr_i[AW];
  end

  assign rd_data_o = bank_q[rd_sel_q];
  assign busy_o    = pend;

  AST_BUSY_AFTER_EDGE: assert property (@(posedge clk) disable iff (rst) (rise[0] && !busy_o[0]) |=> busy_o[0]); // R6
  AST_IRQ_SEPARATE: assert property (@(posedge clk) disable iff (rst) fin[1] |=> !$rose(irq_o[0])); // R5
endmodule

// File: tb/tb_rf_top.sv
module tb_rf_top;
  localparam int MAXW = 12;
  localparam int IRQN = 4;
  localparam int CW   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] done_i = '0, wvld_i = '0;
  logic [31:0] wd [2];
  logic [15:0] tc [2];
  logic [15:0] pri = '0, cpi = '0;
  logic [6:0] wave = '0;
  logic [1:0] busy_o, irq_o;
  logic [4:0] rd_addr = '0;
  logic [31:0] rd_data;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  rf_top #(.MAX_WORDS(MAXW), .IRQ_CYCLES(IRQN), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .done_i(done_i), .wvld_i(wvld_i), .wdata_i({wd[1], wd[0]}),
    .tcount_i({tc[1], tc[0]}), .pri_cnt_i(pri), .cpi_cnt_i(cpi), .wave_i(wave),
    .busy_o(busy_o), .irq_o(irq_o), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  // behavioural reference
  logic [31:0] exp_mem [2][16];
  int  m_len [2], m_flen [2], m_irq [2];
  bit  m_pend [2], dprev [2];
  logic [31:0] m_id [2], m_cnt [2];
  bit  m_act;
  int  m_sel, m_step;

  always @(posedge clk) begin
    bit op [2];
    logic [31:0] s;
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_len[c] = 0; m_irq[c] = 0; m_pend[c] = 0; dprev[c] = 0;
      end
      m_act = 0; m_sel = 0; m_step = 0;
    end else begin
      op = m_pend;
      for (int c = 0; c < 2; c++) begin
        if (m_irq[c] > 0) m_irq[c]--;
        if (wvld_i[c] && !op[c] && m_len[c] < MAXW) begin
          exp_mem[c][3 + m_len[c]] = wd[c];
          m_len[c]++;
        end
        if (done_i[c] && !dprev[c] && !op[c]) begin
          m_pend[c] = 1;
          m_id[c]  = (c == 0) ? {pri, cpi} : {cpi, 9'd0, wave};
          m_cnt[c] = 32'(tc[c]);
        end
        dprev[c] = done_i[c];
      end
      if (!m_act) begin
        if (op[0] || op[1]) begin m_act = 1; m_sel = op[0] ? 0 : 1; m_step = 0; end
      end else if (m_step == 3) begin
        s = m_id[m_sel] + 32'(m_len[m_sel]) + m_cnt[m_sel];
        for (int k = 0; k < m_len[m_sel]; k++) s = s + exp_mem[m_sel][3 + k];
        exp_mem[m_sel][0] = m_id[m_sel];
        exp_mem[m_sel][1] = 32'(m_len[m_sel]);
        exp_mem[m_sel][2] = m_cnt[m_sel];
        exp_mem[m_sel][3 + m_len[m_sel]] = s;
        m_flen[m_sel] = m_len[m_sel];
        m_len[m_sel] = 0;
        m_pend[m_sel] = 0;
        m_irq[m_sel] = IRQN;
        m_act = 0;
      end else m_step++;
    end
  end

  // per-cycle comparison of interrupt (R4, R5) and busy (R6)
  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < 2; c++) begin
        checks++;
        if (irq_o[c] !== (m_irq[c] > 0)) begin
          errors++;
          $display("FAIL R4/R5 irq chain %0d at %0t: got %b exp %b", c, $time, irq_o[c], m_irq[c] > 0);
        end
        checks++;
        if (busy_o[c] !== m_pend[c]) begin
          errors++;
          $display("FAIL R6 busy chain %0d at %0t: got %b exp %b", c, $time, busy_o[c], m_pend[c]);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int c, input logic [31:0] w);
    @(negedge clk);
    wvld_i[c] = 1'b1; wd[c] = w;
    @(negedge clk);
    wvld_i[c] = 1'b0;
  endtask

  task automatic rd_chk(input int c, input int off, input string tag);
    @(negedge clk);
    rd_addr = {c[0], off[3:0]};
    @(negedge clk);
    checks++;
    if (rd_data !== exp_mem[c][off]) begin
      errors++;
      $display("FAIL %s chain %0d offset %0d: got %h exp %h", tag, c, off, rd_data, exp_mem[c][off]);
    end
  endtask

  task automatic check_frame(input int c, input string extra);
    rd_chk(c, 0, {"R2 ", extra});
    rd_chk(c, 1, {"R1 ", extra});
    rd_chk(c, 2, {"R1 ", extra});
    for (int k = 0; k < m_flen[c]; k++) rd_chk(c, 3 + k, {"R1 ", extra});
    rd_chk(c, 3 + m_flen[c], {"R3 ", extra});
  endtask

  task automatic check_len(input int c, input int exp_len, input string tag);
    @(negedge clk);
    rd_addr = {c[0], 4'd1};
    @(negedge clk);
    checks++;
    if (rd_data !== 32'(exp_len)) begin
      errors++;
      $display("FAIL %s chain %0d length: got %0d exp %0d", tag, c, rd_data, exp_len);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wd[0] = '0; wd[1] = '0; tc[0] = '0; tc[1] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    checks++;
    if (irq_o !== 2'b00 || busy_o !== 2'b00) begin
      errors++;
      $display("FAIL R9 reset outputs: irq %b busy %b exp 00 00", irq_o, busy_o);
    end
    // R9: empty frame right after reset, chain 1 identifier (R2)
    cpi = 16'h0007; wave = 7'h05; tc[1] = 16'h0003;
    @(negedge clk); done_i[1] = 1'b1;
    @(negedge clk); done_i[1] = 1'b0;
    idle(12);
    check_len(1, 0, "R9");
    check_frame(1, "R9 empty");

    // chain 0 with three words; done held high afterwards (R4 no retrigger)
    pri = 16'h0011; cpi = 16'h0022; tc[0] = 16'h0002;
    push(0, 32'hA0000001); push(0, 32'hA0000002); push(0, 32'hA0000003);
    @(negedge clk); done_i[0] = 1'b1;
    idle(20);
    check_frame(0, "R4 chain0");
    done_i[0] = 1'b0;

    // chain 1 with wrapping checksum (R3); words and done edges during busy ignored (R6)
    cpi = 16'h0123; wave = 7'h3A; tc[1] = 16'h0005;
    push(1, 32'hFFFFFFFF); push(1, 32'hFFFFFFF0); push(1, 32'h80000000);
    push(1, 32'h80000001); push(1, 32'h00000010);
    @(negedge clk); done_i[1] = 1'b1; wvld_i[1] = 1'b1; wd[1] = 32'hDEAD0001;
    @(negedge clk); done_i[1] = 1'b0; wd[1] = 32'hDEAD0002;
    @(negedge clk); done_i[1] = 1'b1; wvld_i[1] = 1'b0;
    @(negedge clk); done_i[1] = 1'b0;
    idle(10);
    check_frame(1, "R3 wrap");
    tc[1] = 16'h0001;
    push(1, 32'h00000042);
    @(negedge clk); done_i[1] = 1'b1;
    @(negedge clk); done_i[1] = 1'b0;
    idle(10);
    check_len(1, 1, "R6");
    check_frame(1, "R6 next");

    // simultaneous completion (R5)
    tc[0] = 16'h0001; tc[1] = 16'h0002; pri = 16'h0100; cpi = 16'h0200; wave = 7'h11;
    @(negedge clk);
    wvld_i = 2'b11; wd[0] = 32'h11111111; wd[1] = 32'h22222222;
    @(negedge clk);
    wd[0] = 32'h33333333; wd[1] = 32'h44444444;
    @(negedge clk);
    wvld_i = 2'b00; done_i = 2'b11;
    @(negedge clk); done_i = 2'b00;
    idle(20);
    check_frame(0, "R5 first");
    check_frame(1, "R5 second");

    // overflow (R7)
    tc[0] = 16'h000E;
    for (int k = 0; k < 14; k++) push(0, 32'h5000_0000 + 32'(k));
    @(negedge clk); done_i[0] = 1'b1;
    @(negedge clk); done_i[0] = 1'b0;
    idle(12);
    check_len(0, MAXW, "R7");
    check_frame(0, "R7 cap");

    // region separation: chain 1 frame intact after chain 0 activity (R8)
    check_frame(1, "R8 separate");

    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule